// File: doc/BRIEF.md
# Thread-Aware Shared Queue Allocator

This block decides, every cycle, which logical threads may claim one more entry of a queue that they all share, such as an instruction scheduler or a micro-op buffer. It keeps an occupancy count for each thread and a total count for the queue. The payload storage and the choice of which physical entry to free belong to the surrounding logic. The allocator only answers whether a thread's request is granted this cycle.

Software or the pipeline controller picks one of three sharing policies at runtime with a two-bit input. The first gives each thread a fixed, equal slice of the queue. The second lets threads draw from one pool but caps each thread at a programmable ceiling. The third lets any thread take any free entry. When the queue has fewer free entries than there are eligible requesters, the grants rotate among the threads so that none of them starves.

Top module: `shared_queue_alloc`

## Requirements
- R1: After a synchronous active-low reset, every per-thread count and the total count are zero. With no request, no grant is given and no error is raised. The threshold register holds THR_DEFAULT, clamped to CAPACITY.
- R2: With `policy_i` = 0 (equal slice), a thread's limit is CAPACITY / NUM_THREADS, rounded down.
- R3: With `policy_i` = 1 (capped pool), a thread's limit is the value of the threshold register.
- R4: With `policy_i` = 2 or 3 (open pool), a thread's limit is CAPACITY.
- R5: A thread's request is granted only if the total count is below CAPACITY and the thread's own count is below its limit. The decision uses the counts held at the start of the cycle: `grant_o` follows the inputs in the same cycle, and the counts change at the next rising edge. A thread gets at most one entry per cycle.
- R6: If the eligible requesters outnumber the free entries, the block scans from the round-robin pointer upward with wrap-around and grants the first ones up to the number of free entries. After any grant, the pointer moves to one past the highest-scanned thread that was granted. The pointer starts at thread 0.
- R7: A granted request and a valid release by the same thread in the same cycle leave that thread's count and the total unchanged.
- R8: A release from a thread whose count is zero does not change any count. It raises that thread's `rel_err_o` bit in the same cycle.
- R9: `full_o[t]` is high exactly when a request from thread t would be refused under the current counts and policy. Contention with other threads is not taken into account.
- R10: `thr_load_i` writes `thr_value_i` into the threshold register at the next edge only while the total count is zero. A value above CAPACITY is stored as CAPACITY. A load while the queue holds entries is ignored.
- R11: A valid release lowers the thread's count and the total by one at the next edge. The total always equals the sum of the per-thread counts and never exceeds CAPACITY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| policy_i | input | 2 | Sharing policy: 0 equal slice, 1 capped pool, 2/3 open pool |
| thr_load_i | input | 1 | Write the threshold register (honoured only when the queue is empty) |
| thr_value_i | input | CNT_W | New threshold value |
| alloc_req_i | input | NUM_THREADS | Per-thread request for one entry |
| release_i | input | NUM_THREADS | Per-thread release of one entry |
| grant_o | output | NUM_THREADS | Per-thread grant, same cycle as the request |
| full_o | output | NUM_THREADS | Per-thread: a request now would be refused |
| rel_err_o | output | NUM_THREADS | Per-thread: release seen while its count is zero |
| occ_total_o | output | CNT_W | Total occupied entries |
| occ_thread_o | output | NUM_THREADS*CNT_W | Per-thread counts, thread 0 in the low bits |

## Verification
Some properties are checked by assertions on every cycle: the total matches the sum of the per-thread counts and stays within capacity; no grant goes to a thread that is not requesting or that is marked full; grants never outnumber the free entries; the threshold stays put while entries are held; and error releases or paired alloc/release cycles leave a count unchanged. Other behaviour needs the bench's scenarios and its reference model to show it: the exact per-policy limits, the round-robin order under contention and where the pointer lands, the clamping of a threshold load, and a load being refused while the queue is occupied.

// File: rtl/sqa_pkg.sv
// Package: shared types for the shared queue allocator.
// Assumes the two-bit policy encoding listed in the brief.
package sqa_pkg;
    typedef enum logic [1:0] {
        POL_SLICE = 2'd0,
        POL_CAPPED = 2'd1,
        POL_OPEN  = 2'd2,
        POL_OPEN2 = 2'd3
    } policy_e;
endpackage

// File: rtl/sqa_thread_ctr.sv
// Module: per-thread occupancy counter.
// Counts entries held by one thread. A release at zero is dropped and flagged.
// Assumes the grant input already respects capacity and limits.
module sqa_thread_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_i,
    input  logic             release_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rel_ok_o,
    output logic             rel_err_o
);
    logic [CNT_W-1:0] cnt_q;

    // Classify the release as valid or erroneous.
    always_comb begin
        rel_ok_o  = release_i && (cnt_q != '0);
        rel_err_o = release_i && (cnt_q == '0);
    end

    // Count update: +grant, -valid release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (grant_i && !rel_ok_o) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (!grant_i && rel_ok_o) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    p_err_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_err_o && !grant_i) |=> $stable(cnt_q))
        else $error("release at zero changed the count");

    p_pair_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && rel_ok_o) |=> $stable(cnt_q))
        else $error("paired alloc and release changed the count");
endmodule

// File: rtl/sqa_limit_sel.sv
// Module: policy limit and threshold register.
// Picks each thread's limit for the active policy, holds the threshold
// register, and derives per-thread eligibility and full flags.
// Assumes counts never exceed CAPACITY.
module sqa_limit_sel
    import sqa_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int CAPACITY    = 16,
    parameter int THR_DEFAULT = 6,
    parameter int CNT_W       = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   policy_i,
    input  logic                         thr_load_i,
    input  logic [CNT_W-1:0]             thr_value_i,
    input  logic [NUM_THREADS*CNT_W-1:0] cnt_flat_i,
    input  logic [CNT_W-1:0]             total_i,
    output logic [NUM_THREADS-1:0]       below_o,
    output logic [NUM_THREADS-1:0]       full_o
);
    localparam int SHARE    = CAPACITY / NUM_THREADS;
    localparam int THR_INIT = (THR_DEFAULT > CAPACITY) ? CAPACITY : THR_DEFAULT;

    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] limit;
    logic             empty;
    logic             room;

    assign empty = (total_i == '0);
    assign room  = (total_i < CNT_W'(CAPACITY));

    // Threshold register: load while empty, clamp to capacity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= CNT_W'(THR_INIT);
        end else if (thr_load_i && empty) begin
            thr_q <= (thr_value_i > CNT_W'(CAPACITY)) ? CNT_W'(CAPACITY) : thr_value_i;
        end
    end

    // Limit per policy.
    always_comb begin
        case (policy_e'(policy_i))
            POL_SLICE:  limit = CNT_W'(SHARE);
            POL_CAPPED: limit = thr_q;
            default:    limit = CNT_W'(CAPACITY);
        endcase
    end

    // Per-thread eligibility and full indication.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign below_o[t] = room && (cnt_flat_i[t*CNT_W +: CNT_W] < limit);
        assign full_o[t]  = !below_o[t];
    end

    p_thr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        thr_q <= CNT_W'(CAPACITY))
        else $error("threshold above capacity");

    p_thr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |=> $stable(thr_q))
        else $error("threshold changed while occupied");
endmodule

// File: rtl/sqa_rr_arb.sv
// Module: round-robin grant selector.
// Grants eligible threads from the pointer upward until the free entries run
// out, at most one entry per thread. The pointer moves past the last winner.
// Assumes free_i is CAPACITY minus the current total.
module sqa_rr_arb #(
    parameter int NUM_THREADS = 2,
    parameter int CNT_W       = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] elig_i,
    input  logic [CNT_W-1:0]       free_i,
    output logic [NUM_THREADS-1:0] grant_o
);
    localparam int PTR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    // Scan from the pointer and grant up to free_i threads.
    always_comb begin
        int used;
        int idx;
        int last;
        grant_o = '0;
        used    = 0;
        last    = int'(ptr_q);
        for (int k = 0; k < NUM_THREADS; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= NUM_THREADS) idx = idx - NUM_THREADS;
            if (elig_i[idx] && (used < int'(free_i))) begin
                grant_o[idx] = 1'b1;
                used         = used + 1;
                last         = idx;
            end
        end
        if (used == 0) begin
            ptr_d = ptr_q;
        end else if (last + 1 >= NUM_THREADS) begin
            ptr_d = '0;
        end else begin
            ptr_d = PTR_W'(last + 1);
        end
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    p_grant_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~elig_i) == '0)
        else $error("grant to an ineligible thread");

    p_grant_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= int'(free_i))
        else $error("more grants than free entries");
endmodule

// File: rtl/shared_queue_alloc.sv
// Module: shared queue allocator top.
// Joins the per-thread counters, the policy limit logic and the round-robin
// selector, and keeps the total occupancy register.
// Assumes the caller releases only entries that a thread actually holds.
module shared_queue_alloc #(
    parameter int NUM_THREADS = 2,
    parameter int CAPACITY    = 16,
    parameter int THR_DEFAULT = 6,
    parameter int CNT_W       = $clog2(CAPACITY + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   policy_i,
    input  logic                         thr_load_i,
    input  logic [CNT_W-1:0]             thr_value_i,
    input  logic [NUM_THREADS-1:0]       alloc_req_i,
    input  logic [NUM_THREADS-1:0]       release_i,
    output logic [NUM_THREADS-1:0]       grant_o,
    output logic [NUM_THREADS-1:0]       full_o,
    output logic [NUM_THREADS-1:0]       rel_err_o,
    output logic [CNT_W-1:0]             occ_total_o,
    output logic [NUM_THREADS*CNT_W-1:0] occ_thread_o
);
    logic [CNT_W-1:0]             total_q;
    logic [CNT_W-1:0]             total_d;
    logic [CNT_W-1:0]             free_slots;
    logic [NUM_THREADS-1:0]       below;
    logic [NUM_THREADS-1:0]       elig;
    logic [NUM_THREADS-1:0]       rel_ok;
    logic [NUM_THREADS*CNT_W-1:0] cnt_flat;

    assign free_slots = CNT_W'(CAPACITY) - total_q;
    assign elig       = alloc_req_i & below;

    sqa_limit_sel #(
        .NUM_THREADS(NUM_THREADS),
        .CAPACITY   (CAPACITY),
        .THR_DEFAULT(THR_DEFAULT),
        .CNT_W      (CNT_W)
    ) u_limit (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy_i   (policy_i),
        .thr_load_i (thr_load_i),
        .thr_value_i(thr_value_i),
        .cnt_flat_i (cnt_flat),
        .total_i    (total_q),
        .below_o    (below),
        .full_o     (full_o)
    );

    sqa_rr_arb #(
        .NUM_THREADS(NUM_THREADS),
        .CNT_W      (CNT_W)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig_i (elig),
        .free_i (free_slots),
        .grant_o(grant_o)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ctr
        sqa_thread_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .grant_i  (grant_o[t]),
            .release_i(release_i[t]),
            .cnt_o    (cnt_flat[t*CNT_W +: CNT_W]),
            .rel_ok_o (rel_ok[t]),
            .rel_err_o(rel_err_o[t])
        );
    end

    // Next total: add grants, subtract valid releases.
    always_comb begin
        total_d = total_q;
        for (int t = 0; t < NUM_THREADS; t++) begin
            total_d = total_d + CNT_W'(grant_o[t]) - CNT_W'(rel_ok[t]);
        end
    end

    // Total occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) total_q <= '0;
        else        total_q <= total_d;
    end

    assign occ_total_o  = total_q;
    assign occ_thread_o = cnt_flat;

    // Sum of the per-thread counts, used only by the checks below.
    logic [CNT_W+7:0] cnt_sum;
    always_comb begin
        cnt_sum = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            cnt_sum = cnt_sum + (CNT_W+8)'(cnt_flat[t*CNT_W +: CNT_W]);
        end
    end

    p_total_is_sum_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_sum == (CNT_W+8)'(total_q))
        else $error("total differs from sum of counts");

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        total_q <= CNT_W'(CAPACITY))
        else $error("total above capacity");

    p_full_blocks_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & full_o) == '0)
        else $error("grant to a full thread");
endmodule

// File: tb/shared_queue_alloc_test.sv
// Bench: a driver task applies one cycle of stimulus, computes the expected
// outputs from a reference model and queues them; a monitor pops and compares.
module shared_queue_alloc_test;
    localparam int NT  = 3;
    localparam int CAP = 9;
    localparam int THD = 12;
    localparam int CW  = $clog2(CAP + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        policy = 2'd0;
    logic              thr_load = 1'b0;
    logic [CW-1:0]     thr_value = '0;
    logic [NT-1:0]     req = '0;
    logic [NT-1:0]     rel = '0;
    logic [NT-1:0]     grant, full, err;
    logic [CW-1:0]     tot;
    logic [NT*CW-1:0]  occ;

    always #2 clk = ~clk;

    shared_queue_alloc #(
        .NUM_THREADS(NT), .CAPACITY(CAP), .THR_DEFAULT(THD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .policy_i(policy), .thr_load_i(thr_load),
        .thr_value_i(thr_value), .alloc_req_i(req), .release_i(rel),
        .grant_o(grant), .full_o(full), .rel_err_o(err),
        .occ_total_o(tot), .occ_thread_o(occ)
    );

    typedef struct {
        logic [NT-1:0]    g;
        logic [NT-1:0]    f;
        logic [NT-1:0]    e;
        logic [CW-1:0]    t;
        logic [NT*CW-1:0] o;
        string            tag;
    } exp_t;

    exp_t q[$];
    event ev;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Reference model state.
    int m_cnt[NT];
    int m_tot;
    int m_thr;
    int m_ptr;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v,
                       input string what);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp_v);
        end
    endtask

    // Monitor: compare DUT outputs with queued expectations.
    initial begin
        forever begin
            @(ev);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                chk(x.tag, 64'(grant), 64'(x.g), "grant");
                chk(x.tag, 64'(full),  64'(x.f), "full");
                chk(x.tag, 64'(err),   64'(x.e), "rel_err");
                chk(x.tag, 64'(tot),   64'(x.t), "total");
                chk(x.tag, 64'(occ),   64'(x.o), "per-thread counts");
            end
        end
    end

    task automatic model_reset();
        for (int t = 0; t < NT; t++) m_cnt[t] = 0;
        m_tot = 0;
        m_thr = (THD > CAP) ? CAP : THD;
        m_ptr = 0;
    endtask

    // Driver: one cycle of stimulus plus expected results.
    task automatic step(input logic [1:0] pol, input logic ld, input int val,
                        input logic [NT-1:0] rq, input logic [NT-1:0] rl, input string tag);
        exp_t x;
        int lim, used, last, idx, freec;
        @(negedge clk);
        policy = pol; thr_load = ld; thr_value = CW'(val); req = rq; rel = rl;
        lim = (pol == 2'd0) ? CAP / NT : (pol == 2'd1) ? m_thr : CAP;
        freec = CAP - m_tot;
        x.g = '0; x.f = '0; x.e = '0; used = 0; last = m_ptr;
        for (int t = 0; t < NT; t++) x.f[t] = !(m_tot < CAP && m_cnt[t] < lim);
        for (int k = 0; k < NT; k++) begin
            idx = (m_ptr + k) % NT;
            if (rq[idx] && !x.f[idx] && used < freec) begin
                x.g[idx] = 1'b1; used++; last = idx;
            end
        end
        for (int t = 0; t < NT; t++) x.e[t] = rl[t] && (m_cnt[t] == 0);
        x.t = CW'(m_tot);
        x.o = '0;
        for (int t = 0; t < NT; t++) x.o[t*CW +: CW] = CW'(m_cnt[t]);
        x.tag = tag;
        q.push_back(x);
        ->ev;
        @(posedge clk);
        if (ld && m_tot == 0) m_thr = (val > CAP) ? CAP : val;
        if (used > 0) m_ptr = (last + 1) % NT;
        for (int t = 0; t < NT; t++) begin
            int d;
            d = int'(x.g[t]) - ((rl[t] && m_cnt[t] != 0) ? 1 : 0);
            m_cnt[t] += d;
            m_tot += d;
        end
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < CAP + 1; i++) step(2'd2, 1'b0, 0, '0, '1, tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        step(2'd0, 0, 0, '0, '0, "R1 reset idle");
        // R2 equal slice: thread 0 capped at 3 of 9
        for (int i = 0; i < 4; i++) step(2'd0, 0, 0, 3'b001, '0, "R2 slice limit");
        step(2'd0, 0, 0, 3'b001, '0, "R9 full at slice");
        // R7 paired alloc+release at limit refused; below limit holds count
        step(2'd0, 0, 0, 3'b001, 3'b001, "R11 release lowers count");
        step(2'd0, 0, 0, 3'b001, 3'b001, "R7 paired keeps count");
        // R8 release at zero ignored
        step(2'd0, 0, 0, '0, 3'b010, "R8 release at zero");
        step(2'd0, 0, 0, '0, '0, "R8 count unchanged");
        // R10 load while occupied ignored
        step(2'd1, 1, 2, '0, '0, "R10 load while occupied");
        for (int i = 0; i < 4; i++) step(2'd1, 0, 0, 3'b100, '0, "R3 default threshold");
        drain("R11 drain");
        // R10 load when empty, then R3 cap
        step(2'd1, 1, 5, '0, '0, "R10 load empty");
        for (int i = 0; i < 6; i++) step(2'd1, 0, 0, 3'b010, '0, "R3 capped pool");
        drain("R11 drain");
        // R10 clamp
        step(2'd1, 1, 15, '0, '0, "R10 clamp load");
        for (int i = 0; i < 10; i++) step(2'd1, 0, 0, 3'b001, '0, "R10 clamp to capacity");
        drain("R11 drain");
        // R4 open pool and R6 contention
        for (int i = 0; i < 7; i++) step(2'd2, 0, 0, 3'b001, '0, "R4 open pool");
        step(2'd3, 0, 0, 3'b111, '0, "R6 contention two free");
        step(2'd2, 0, 0, 3'b111, 3'b100, "R5 capacity reached");
        step(2'd2, 0, 0, 3'b111, '0, "R6 single free");
        step(2'd2, 0, 0, 3'b111, 3'b011, "R6 rotate");
        step(2'd2, 0, 0, 3'b111, '0, "R6 two free again");
        drain("R11 drain");
        // Random traffic across all policies
        for (int i = 0; i < 600; i++)
            step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 7) == 0),
                 $urandom_range(0, 15), 3'($urandom), 3'($urandom & $urandom), "R5 random");
        @(negedge clk);
        #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule